// File: doc/BRIEF.md
# Serial Nibble-Register Access Master

This block drives a three-wire serial link to a clock chip whose registers are four bits wide. It takes one read or write request at a time through a valid/ready handshake. Each request carries a 4-bit register address and, for a write, 4-bit data. The block raises chip-enable for the whole transfer and produces one shift-clock pulse per bit. It shifts out the command fields on a shared data pin. For a read it turns the pin around and brings back the 4-bit register value together with a one-cycle done pulse.

Every transfer is 16 bit slots long. Each slot holds its bit low for `HALF` system cycles and then high for `HALF` cycles. The master changes outgoing bits only while the shift clock is low. It samples the incoming bit at the system edge that raises the shift clock.

Top module: `nib_ser_master`

## Requirements
- R1: After reset, and whenever idle, `ce_o`, `sclk_o`, `sd_oe_o`, `sd_o` and `done_o` are 0 and `req_ready_o` is 1.
- R2: A request is accepted at a rising edge where `req_valid_i` and `req_ready_o` are both 1. `req_ready_o` is 0 from the next cycle through the done cycle and returns to 1 the cycle after done. Requests presented while `req_ready_o` is 0 are ignored.
- R3: Counting from the acceptance edge, cycle t of a transfer (0 <= t < 32*HALF) has `ce_o` = 1 and `sclk_o` = (t/HALF) mod 2. This gives exactly 16 shift-clock pulses.
- R4: A read (`req_write_i` = 0) drives slots 0..7 in order with the bits 1, 1, 1, 0 followed by A3, A2, A1, A0, most significant first.
- R5: For a read, `sd_oe_o` is 0 from slot 8 onward. The bits sampled in slots 8..11 are discarded. The bits sampled in slots 12..15 become `rdata_o`[3:0], most significant first, and are valid in the done cycle.
- R6: A write (`req_write_i` = 1) keeps `sd_oe_o` = 1 in all 16 slots. It drives 1, 0, 1, 0, then A3..A0, then 1, 0, 0, 1, then D3..D0.
- R7: `done_o` is a single-cycle pulse in cycle t = 32*HALF after acceptance. In that cycle `ce_o`, `sclk_o` and `sd_oe_o` are already 0.
- R8: `sd_o` never changes while `sclk_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Master idle, request can be taken |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 4 | Register address |
| req_wdata_i | input | 4 | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 4 | Read result, valid with done |
| ce_o | output | 1 | Chip-enable, high during a transfer |
| sclk_o | output | 1 | Shift clock |
| sd_o | output | 1 | Serial data out |
| sd_oe_o | output | 1 | Data pin drive enable |
| sd_i | input | 1 | Serial data in |

## Verification
The shift clock rises HALF cycles after each slot starts. Slot k begins 2*k*HALF cycles after the acceptance edge. The done pulse is due exactly 32*HALF cycles after acceptance, and ready returns one cycle later. The bench runs a behavioural model that counts cycles from each acceptance it predicts. The model derives every expected pin value from that count and compares all outputs on the falling clock edge of every cycle. The model also drives `sd_i` with the bit of the current slot so that the bit is stable at the rising edge where the master samples it. It puts inverted garbage on the pin during the discarded slots.

// File: rtl/nsm_pkg.sv
package nsm_pkg;
  localparam int NIB_W   = 4;
  localparam int SLOTS   = 16;
  localparam int SLOT_W  = $clog2(SLOTS);
  localparam int TURN_AT = 8;   // first slot with pin released on reads
  localparam int CAP_AT  = 12;  // first captured slot on reads

  localparam logic [NIB_W-1:0] CMD_RD   = 4'b1110;
  localparam logic [NIB_W-1:0] CMD_WR_A = 4'b1010;
  localparam logic [NIB_W-1:0] CMD_WR_D = 4'b1001;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} st_e;
endpackage

// File: rtl/nsm_tick.sv
module nsm_tick #(
  parameter int HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/nsm_frame.sv
module nsm_frame
  import nsm_pkg::*;
(
  input  logic             write_i,
  input  logic [NIB_W-1:0] addr_i,
  input  logic [NIB_W-1:0] data_i,
  output logic [SLOTS-1:0] frame_o,
  output logic [SLOTS-1:0] drive_o
);
  assign frame_o = write_i ? {CMD_WR_A, addr_i, CMD_WR_D, data_i}
                           : {CMD_RD, addr_i, {(2*NIB_W){1'b0}}};

  // slot k maps to bit SLOTS-1-k
  for (genvar k = 0; k < SLOTS; k++) begin : g_drv
    assign drive_o[SLOTS-1-k] = write_i || (k < TURN_AT);
  end
endmodule

// File: rtl/nsm_seq.sv
module nsm_seq
  import nsm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic             run_o,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic [SLOTS-1:0] frame_i,
  input  logic [SLOTS-1:0] drive_i,
  output logic             done_o,
  output logic [NIB_W-1:0] rdata_o,
  output logic             ce_o,
  output logic             sclk_o,
  output logic             sd_o,
  output logic             sd_oe_o,
  input  logic             sd_i
);
  st_e              st_q;
  logic             hi_q;
  logic             wr_q;
  logic [SLOT_W-1:0] slot_q;
  logic [SLOTS-1:0] sh_q;
  logic [SLOTS-1:0] dm_q;

  assign run_o       = (st_q == ST_RUN);
  assign req_ready_o = (st_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      hi_q    <= 1'b0;
      wr_q    <= 1'b0;
      slot_q  <= '0;
      sh_q    <= '0;
      dm_q    <= '0;
      done_o  <= 1'b0;
      rdata_o <= '0;
      ce_o    <= 1'b0;
      sclk_o  <= 1'b0;
      sd_o    <= 1'b0;
      sd_oe_o <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          done_o <= 1'b0;
          if (req_valid_i) begin
            st_q    <= ST_RUN;
            hi_q    <= 1'b0;
            wr_q    <= req_write_i;
            slot_q  <= '0;
            sh_q    <= frame_i;
            dm_q    <= drive_i;
            ce_o    <= 1'b1;
            sclk_o  <= 1'b0;
            sd_oe_o <= drive_i[SLOTS-1];
            sd_o    <= frame_i[SLOTS-1] & drive_i[SLOTS-1];
          end
        end
        ST_RUN: begin
          if (tick_i) begin
            if (!hi_q) begin
              hi_q   <= 1'b1;
              sclk_o <= 1'b1;
              if (!wr_q && slot_q >= SLOT_W'(CAP_AT))
                rdata_o <= {rdata_o[NIB_W-2:0], sd_i};
            end else begin
              hi_q   <= 1'b0;
              sclk_o <= 1'b0;
              if (slot_q == SLOT_W'(SLOTS - 1)) begin
                st_q    <= ST_DONE;
                ce_o    <= 1'b0;
                sd_oe_o <= 1'b0;
                sd_o    <= 1'b0;
                done_o  <= 1'b1;
              end else begin
                slot_q  <= slot_q + 1'b1;
                sh_q    <= sh_q << 1;
                dm_q    <= dm_q << 1;
                sd_oe_o <= dm_q[SLOTS-2];
                sd_o    <= sh_q[SLOTS-2] & dm_q[SLOTS-2];
              end
            end
          end
        end
        default: begin
          st_q   <= ST_IDLE;
          done_o <= 1'b0;
        end
      endcase
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!ce_o && !sclk_o && !sd_oe_o && !done_o)) else $error("AST_IDLE_QUIET"); // R1
  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> (!req_ready_o && ce_o)) else $error("AST_ACCEPT_BUSY"); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && req_ready_o)) else $error("AST_DONE_SINGLE"); // R7
  AST_READ_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !wr_q && slot_q >= SLOT_W'(TURN_AT)) |-> !sd_oe_o) else $error("AST_READ_RELEASED"); // R5
  AST_SD_HELD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(sd_o)) else $error("AST_SD_HELD_HIGH"); // R8
endmodule

// File: rtl/nib_ser_master.sv
module nib_ser_master
  import nsm_pkg::*;
#(
  parameter int HALF = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_write_i,
  input  logic [NIB_W-1:0] req_addr_i,
  input  logic [NIB_W-1:0] req_wdata_i,
  output logic             done_o,
  output logic [NIB_W-1:0] rdata_o,
  output logic             ce_o,
  output logic             sclk_o,
  output logic             sd_o,
  output logic             sd_oe_o,
  input  logic             sd_i
);
  logic             tick, run;
  logic [SLOTS-1:0] frame, drive;

  nsm_tick #(.HALF(HALF)) u_tick (
    .clk_i (clk_i), .rst_ni(rst_ni), .run_i(run), .tick_o(tick)
  );

  nsm_frame u_frame (
    .write_i(req_write_i), .addr_i(req_addr_i), .data_i(req_wdata_i),
    .frame_o(frame), .drive_o(drive)
  );

  nsm_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .run_o      (run),
    .req_valid_i(req_valid_i),
    .req_ready_o(req_ready_o),
    .req_write_i(req_write_i),
    .frame_i    (frame),
    .drive_i    (drive),
    .done_o     (done_o),
    .rdata_o    (rdata_o),
    .ce_o       (ce_o),
    .sclk_o     (sclk_o),
    .sd_o       (sd_o),
    .sd_oe_o    (sd_oe_o),
    .sd_i       (sd_i)
  );
endmodule

// File: tb/sim_nib_ser_master.sv
`timescale 1ns/1ps
module sim_nib_ser_master;
  localparam int H = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic valid = 1'b0, write = 1'b0;
  logic [3:0] addr = '0, wdata = '0;
  logic [3:0] sdata = '0;  // slave's answer for the next read
  logic sd_i = 1'b1;
  logic ready, done, ce, sclk, sd_o, sd_oe;
  logic [3:0] rdata;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  // model state: 0 idle, 1 running, 2 done
  int m_mode = 0, m_t = 0;
  logic m_wr = 1'b0;
  logic [15:0] m_frame = '0;
  logic [3:0] m_sdata = '0;

  always #5 clk = ~clk;

  nib_ser_master #(.HALF(H)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_ready_o(ready),
    .req_write_i(write), .req_addr_i(addr), .req_wdata_i(wdata),
    .done_o(done), .rdata_o(rdata), .ce_o(ce), .sclk_o(sclk),
    .sd_o(sd_o), .sd_oe_o(sd_oe), .sd_i(sd_i)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s t=%0d act=%0d exp=%0d (cycle %0d)", tag, m_t, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode <= 0; m_t <= 0;
    end else begin
      cyc <= cyc + 1;
      case (m_mode)
        0: if (valid) begin
             m_mode <= 1; m_t <= 0; m_wr <= write; m_sdata <= sdata;
             m_frame <= write ? {4'b1010, addr, 4'b1001, wdata} : {4'b1110, addr, 8'h00};
           end
        1: begin
             if (m_t + 1 == 32 * H) m_mode <= 2;
             m_t <= m_t + 1;
           end
        default: m_mode <= 0;
      endcase
    end
  end

  // compare every cycle away from the active edge; also play the slave
  always @(negedge clk) begin
    int k;
    logic e_oe, e_sd;
    k = m_t / (2 * H);
    case (m_mode)
      0: begin
        chk(ready == 1'b1, "R1 ready", ready, 1);
        chk(ce == 1'b0 && sclk == 1'b0 && sd_oe == 1'b0 && sd_o == 1'b0, "R1 pins idle",
            {ce, sclk, sd_oe, sd_o}, 0);
        chk(done == 1'b0, "R7 done idle", done, 0);
        sd_i = 1'b1;
      end
      1: begin
        e_oe = m_wr || (k < 8);
        e_sd = e_oe ? m_frame[15-k] : 1'b0;
        chk(ready == 1'b0, "R2 ready busy", ready, 0);
        chk(ce == 1'b1, "R3 ce", ce, 1);
        chk(sclk == logic'((m_t / H) % 2), "R3 sclk", sclk, (m_t / H) % 2);
        chk(done == 1'b0, "R7 done early", done, 0);
        if (m_wr) begin
          chk(sd_oe == e_oe, "R6 oe", sd_oe, e_oe);
          chk(sd_o == e_sd, "R6 sd_o", sd_o, e_sd);
        end else begin
          chk(sd_oe == e_oe, "R5 oe", sd_oe, e_oe);
          if (k < 8) chk(sd_o == e_sd, "R4 sd_o", sd_o, e_sd);
        end
        if (k >= 12)     sd_i = m_sdata[15-k];
        else if (k >= 8) sd_i = ~m_sdata[k-8];   // garbage in discarded slots
        else             sd_i = ~sd_o;
      end
      default: begin
        chk(done == 1'b1, "R7 done", done, 1);
        chk(ready == 1'b0, "R2 ready at done", ready, 0);
        chk(ce == 1'b0 && sclk == 1'b0 && sd_oe == 1'b0, "R7 pins at done", {ce, sclk, sd_oe}, 0);
        if (!m_wr) chk(rdata == m_sdata, "R5 rdata", rdata, m_sdata);
      end
    endcase
  end

  // one request; if noise, pulse a bogus request while busy (R2)
  task automatic req(input logic w, input logic [3:0] a, input logic [3:0] d,
                     input logic [3:0] s, input logic noise);
    @(negedge clk);
    valid = 1'b1; write = w; addr = a; wdata = d; sdata = s;
    @(negedge clk);
    while (m_mode == 0) @(negedge clk);
    valid = 1'b0;
    if (noise) begin
      repeat (5 * H) @(negedge clk);
      valid = 1'b1; write = ~w; addr = ~a; wdata = ~d; sdata = ~s;
      @(negedge clk);
      valid = 1'b0;
    end
    while (m_mode != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ready == 1'b1 && ce == 1'b0 && sclk == 1'b0 && sd_oe == 1'b0, "R1 reset",
        {ready, ce, sclk, sd_oe}, 8);
    rst_n = 1'b1;
    req(1'b0, 4'h5, 4'h0, 4'hA, 1'b0);   // R4 R5 read
    req(1'b1, 4'hC, 4'h3, 4'h0, 1'b0);   // R6 write
    req(1'b0, 4'hF, 4'h0, 4'h0, 1'b1);   // R2 ignored request while busy
    req(1'b0, 4'h0, 4'h0, 4'hF, 1'b0);
    req(1'b1, 4'h0, 4'h0, 4'h0, 1'b1);
    req(1'b1, 4'hF, 4'hF, 4'h0, 1'b0);
    // back to back: valid held high, second taken the cycle after done (R2)
    @(negedge clk);
    valid = 1'b1; write = 1'b0; addr = 4'h9; sdata = 4'h6;
    while (m_mode != 2) @(negedge clk);
    write = 1'b1; addr = 4'h3; wdata = 4'h5;
    @(negedge clk);
    @(negedge clk);
    chk(m_mode == 1 && ready == 1'b0, "R2 back-to-back accept", ready, 0);
    valid = 1'b0;
    while (m_mode != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule